// File: doc/BRIEF.md
# Keyboard Matrix Column Scanner

This block walks a passive key matrix one column at a time and keeps a debounced map of every key that is held down. At any moment exactly one column output is pulled low while the rest stay high. A closed switch in that column then connects the column to its row line, so the row input reads low. The row inputs are asynchronous to the block's clock. They pass through a two-stage synchronizer, and the block samples them only after the column has been held for a settle interval.

Each key has its own debounce counter. A new level for a key is accepted only after it has been sampled the same way on a set number of consecutive full sweeps. After the last column of a sweep has been sampled, the block raises a single-cycle sweep strobe. The host can then read a map that covers every key. Translating keys to characters and any register access by software are left to the surrounding logic.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: In reset and afterwards, exactly one bit of `cols_n` is 0 and every other bit is 1. The reset state is column 0 active (`cols_n` = 8'hFE), `key_map` all zero and `scan_done` low.
- R2: Columns are visited in ascending index order and wrap from the last column to column 0. Each column is held for exactly SETTLE_CYCLES clocks (default 16). The first column after reset is also held for SETTLE_CYCLES clocks, counted from the first clock edge with `rst_n` high.
- R3: A key counts as closed in a sample when its row input reads 0 while its column is the one driven low. The sample is taken in the last clock of the column's hold time, from the synchronized row lines. Key (column c, row r) occupies `key_map` bit c*NUM_ROWS + r, and a 1 in that bit means pressed.
- R4: A bit of `key_map` changes only after the opposite level has been sampled for that key on DEBOUNCE_SCANS consecutive sweeps (default 4). The change becomes visible on the fourth such sample.
- R5: A level that differs from the reported one for fewer than DEBOUNCE_SCANS consecutive sweeps, and then returns, leaves the reported bit unchanged.
- R6: `scan_done` is high for exactly one clock, in the first clock after the last column has been sampled, which is also the first clock in which column 0 is driven again. Successive pulses are NUM_COLS*SETTLE_CYCLES clocks apart.
- R7: `key_map` changes only on a clock edge at which the driven column advances.
- R8: Keys are debounced independently, so any number of keys held at the same time, in one column or in several, are all reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rows_n | input | NUM_ROWS (7) | Row lines from the matrix, low when a key in the driven column is closed; asynchronous |
| cols_n | output | NUM_COLS (8) | Column drive, one bit low at a time |
| key_map | output | NUM_COLS*NUM_ROWS (56) | Debounced pressed-key map, bit c*NUM_ROWS+r |
| scan_done | output | 1 | One-clock strobe at the end of every full sweep |

## Verification
The assertions assume that SETTLE_CYCLES is larger than the synchronizer depth. They also assume that the matrix itself has no memory, so a row is low only while a closed key's column is driven. The stimulus models an ideal matrix: a row is pulled low exactly when a pressed key sits in the driven column. Key states change only at the sweep strobe, so every column of a sweep sees one consistent set of pressed keys. A fixed-seed random walk of key presses, releases and short bounces is checked sweep by sweep against a per-key counter model held in the bench.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   // width of a counter that must hold values 0..n-1, never zero
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/kbd_row_sync.sv
module kbd_row_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_n,
   output logic [WIDTH-1:0] dout_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("kbd_row_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q[s] <= '1;
         end else begin
            stage_q[s] <= (s == 0) ? din_n : stage_q[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign dout_n = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_col_sequencer.sv
module kbd_col_sequencer
   import kbd_scan_pkg::*;
#(
   parameter int unsigned NUM_COLS      = 8,
   parameter int unsigned SETTLE_CYCLES = 16,
   localparam int unsigned CW = cnt_width(NUM_COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [CW-1:0]       col_idx,
   output logic [NUM_COLS-1:0] cols_n,
   output logic                sample_en,
   output logic                sweep_end
);

   localparam int unsigned SW = cnt_width(SETTLE_CYCLES);
   localparam logic [SW-1:0] DWELL_LAST = SW'(SETTLE_CYCLES - 1);
   localparam logic [CW-1:0] COL_LAST   = CW'(NUM_COLS - 1);

   logic [SW-1:0] dwell_q;
   logic [CW-1:0] col_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dwell_q <= '0;
         col_q   <= '0;
      end else if (dwell_q == DWELL_LAST) begin
         dwell_q <= '0;
         col_q   <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
      end else begin
         dwell_q <= dwell_q + 1'b1;
      end
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_drive
      assign cols_n[c] = (col_q != CW'(c));
   end

   assign col_idx   = col_q;
   assign sample_en = (dwell_q == DWELL_LAST);
   assign sweep_end = sample_en && (col_q == COL_LAST);

endmodule

// File: rtl/kbd_key_debounce.sv
module kbd_key_debounce
   import kbd_scan_pkg::*;
#(
   parameter int unsigned NUM_COLS       = 8,
   parameter int unsigned NUM_ROWS       = 7,
   parameter int unsigned DEBOUNCE_SCANS = 4,
   localparam int unsigned CW   = cnt_width(NUM_COLS),
   localparam int unsigned KEYS = NUM_COLS * NUM_ROWS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_en,
   input  logic [CW-1:0]       col_idx,
   input  logic [NUM_ROWS-1:0] row_closed,
   output logic [KEYS-1:0]     key_map
);

   localparam int unsigned DW = cnt_width(DEBOUNCE_SCANS);
   localparam logic [DW-1:0] RUN_LAST = DW'(DEBOUNCE_SCANS - 1);

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic col_hit;
      assign col_hit = sample_en && (col_idx == CW'(c));

      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
         localparam int unsigned K = c * NUM_ROWS + r;
         logic [DW-1:0] run_q;
         logic          level_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q   <= '0;
               level_q <= 1'b0;
            end else if (col_hit) begin
               if (row_closed[r] == level_q) begin
                  run_q <= '0;
               end else if (run_q == RUN_LAST) begin
                  run_q   <= '0;
                  level_q <= row_closed[r];
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end

         assign key_map[K] = level_q;
      end
   end

endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
   import kbd_scan_pkg::*;
#(
   parameter int unsigned NUM_COLS       = 8,
   parameter int unsigned NUM_ROWS       = 7,
   parameter int unsigned SETTLE_CYCLES  = 16,
   parameter int unsigned DEBOUNCE_SCANS = 4,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_ROWS-1:0]          rows_n,
   output logic [NUM_COLS-1:0]          cols_n,
   output logic [NUM_COLS*NUM_ROWS-1:0] key_map,
   output logic                         scan_done
);

   localparam int unsigned CW = cnt_width(NUM_COLS);

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("kbd_matrix_scanner: NUM_COLS must be at least 2");
   end
   if (NUM_ROWS < 1) begin : g_bad_rows
      $error("kbd_matrix_scanner: NUM_ROWS must be at least 1");
   end
   if (SETTLE_CYCLES <= SYNC_STAGES) begin : g_bad_settle
      $error("kbd_matrix_scanner: SETTLE_CYCLES must exceed SYNC_STAGES");
   end
   if (DEBOUNCE_SCANS < 2) begin : g_bad_debounce
      $error("kbd_matrix_scanner: DEBOUNCE_SCANS must be at least 2");
   end

   logic [NUM_ROWS-1:0] rows_sync_n;
   logic [CW-1:0]       col_idx;
   logic                sample_en;
   logic                sweep_end;
   logic                done_q;

   kbd_row_sync #(
      .WIDTH  (NUM_ROWS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_n  (rows_n),
      .dout_n (rows_sync_n)
   );

   kbd_col_sequencer #(
      .NUM_COLS      (NUM_COLS),
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_idx   (col_idx),
      .cols_n    (cols_n),
      .sample_en (sample_en),
      .sweep_end (sweep_end)
   );

   kbd_key_debounce #(
      .NUM_COLS       (NUM_COLS),
      .NUM_ROWS       (NUM_ROWS),
      .DEBOUNCE_SCANS (DEBOUNCE_SCANS)
   ) u_deb (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en),
      .col_idx    (col_idx),
      .row_closed (~rows_sync_n),
      .key_map    (key_map)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= sweep_end;
   end

   assign scan_done = done_q;

endmodule

// File: rtl/kbd_matrix_scanner_chk.sv
module kbd_matrix_scanner_chk #(
   parameter int unsigned NUM_COLS      = 8,
   parameter int unsigned NUM_ROWS      = 7,
   parameter int unsigned SETTLE_CYCLES = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_COLS-1:0]          cols_n,
   input logic [NUM_COLS*NUM_ROWS-1:0] key_map,
   input logic                         scan_done
);

   logic [NUM_COLS-1:0] prev_cols_q;
   int unsigned         hold_q;
   logic                col_moved;

   assign col_moved = (cols_n != prev_cols_q);

   always_ff @(posedge clk) begin
      prev_cols_q <= cols_n;
      if (!rst_n)         hold_q <= 0;
      else if (col_moved) hold_q <= 1;
      else                hold_q <= hold_q + 1;
   end

   assert_one_col_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cols_n) == 1);

   assert_col_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cols_n != $past(cols_n)) |->
         (cols_n == {$past(cols_n[NUM_COLS-2:0]), $past(cols_n[NUM_COLS-1])}));

   assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      col_moved |-> (hold_q == SETTLE_CYCLES));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);

   assert_done_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> (!cols_n[0] && !$past(cols_n[NUM_COLS-1])));

   assert_map_on_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (key_map != $past(key_map)) |-> (cols_n != $past(cols_n)));

endmodule

bind kbd_matrix_scanner kbd_matrix_scanner_chk #(
   .NUM_COLS      (NUM_COLS),
   .NUM_ROWS      (NUM_ROWS),
   .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cols_n    (cols_n),
   .key_map   (key_map),
   .scan_done (scan_done)
);

// File: tb/kbd_matrix_scanner_bench.sv
module kbd_matrix_scanner_bench;

   localparam int COLS       = 8;
   localparam int ROWS       = 7;
   localparam int KEYS       = COLS * ROWS;
   localparam int SETTLE     = 16;
   localparam int DEB        = 4;
   localparam int SWEEP      = COLS * SETTLE;
   localparam int CLK_PERIOD = 10;

   logic            clk   = 1'b0;
   logic            rst_n = 1'b0;
   logic [KEYS-1:0] phys  = '0;
   logic [ROWS-1:0] rows_n;
   logic [COLS-1:0] cols_n;
   logic [KEYS-1:0] key_map;
   logic            scan_done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   logic [KEYS-1:0] exp_map = '0;
   int              run_cnt [KEYS];

   logic [KEYS-1:0] prev_map  = '0;
   logic [COLS-1:0] prev_cols = '1;

   always #(CLK_PERIOD/2) clk = ~clk;

   // ideal matrix: a row is low when a pressed key sits in the driven column
   always_comb begin
      rows_n = '1;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++)
            if (!cols_n[c] && phys[c*ROWS + r]) rows_n[r] = 1'b0;
   end

   kbd_matrix_scanner u_kbd_matrix_scanner (
      .clk       (clk),
      .rst_n     (rst_n),
      .rows_n    (rows_n),
      .cols_n    (cols_n),
      .key_map   (key_map),
      .scan_done (scan_done)
   );

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // cycle monitor: column timing, sweep strobe, map update points
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int col;
         logic [COLS-1:0] exp_cols;
         col      = (cyc / SETTLE) % COLS;
         exp_cols = ~(COLS'(1) << col);
         check(cols_n == exp_cols, "R2 column sequence", 64'(cols_n), 64'(exp_cols));
         check(scan_done == (cyc > 0 && cyc % SWEEP == 0), "R6 sweep strobe",
               64'(scan_done), 64'(cyc > 0 && cyc % SWEEP == 0));
         if (key_map != prev_map)
            check(cols_n != prev_cols, "R7 map changes only at column advance",
                  64'(cols_n), 64'(prev_cols));
      end
      prev_map  = key_map;
      prev_cols = cols_n;
   end

   task automatic model_sweep(input logic [KEYS-1:0] p);
      for (int k = 0; k < KEYS; k++) begin
         if (p[k] == exp_map[k]) begin
            run_cnt[k] = 0;
         end else if (run_cnt[k] == DEB - 1) begin
            run_cnt[k] = 0;
            exp_map[k] = p[k];
         end else begin
            run_cnt[k] = run_cnt[k] + 1;
         end
      end
   endtask

   // apply a key pattern for one full sweep and compare the map at its strobe
   task automatic run_sweep(input logic [KEYS-1:0] p, input string req);
      phys = p;
      do @(negedge clk); while (!scan_done);
      model_sweep(p);
      check(key_map == exp_map, req, 64'(key_map), 64'(exp_map));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [KEYS-1:0] p;
      logic [KEYS-1:0] held;
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < KEYS; k++) run_cnt[k] = 0;

      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(cols_n == 8'hFE, "R1 reset column drive", 64'(cols_n), 64'hFE);
      check(key_map == '0, "R1 reset map", 64'(key_map), 64'h0);
      check(scan_done == 1'b0, "R1 reset strobe", 64'(scan_done), 64'h0);
      rst_n = 1'b1;

      // R3/R4: corner keys (col 0 row 0 -> bit 0, col 7 row 6 -> bit 55)
      p = '0;
      p[0]  = 1'b1;
      p[55] = 1'b1;
      for (int s = 1; s <= DEB; s++) begin
         run_sweep(p, "R4 corner keys debounce");
         check(key_map[0] == (s == DEB), "R3 key bit 0 position",
               64'(key_map[0]), 64'(s == DEB));
         check(key_map[55] == (s == DEB), "R3 key bit 55 position",
               64'(key_map[55]), 64'(s == DEB));
      end
      for (int s = 1; s <= DEB; s++) run_sweep('0, "R4 release debounce");
      check(key_map == '0, "R4 released", 64'(key_map), 64'h0);

      // R5: bounce shorter than the debounce length is ignored
      p = '0;
      p[20] = 1'b1;
      for (int s = 1; s < DEB; s++) begin
         run_sweep(p, "R5 short press");
         check(key_map[20] == 1'b0, "R5 short press ignored", 64'(key_map[20]), 64'h0);
      end
      for (int s = 1; s <= DEB; s++) begin
         run_sweep('0, "R5 after bounce");
         check(key_map[20] == 1'b0, "R5 bit stays clear", 64'(key_map[20]), 64'h0);
      end

      // R8: whole column 3 plus a key in column 1 held together
      p = '0;
      for (int r = 0; r < ROWS; r++) p[3*ROWS + r] = 1'b1;
      p[1*ROWS + 2] = 1'b1;
      for (int s = 1; s <= DEB; s++) run_sweep(p, "R8 multiple keys");
      check(key_map == p, "R8 all held keys reported", 64'(key_map), 64'(p));

      // R4 release of held keys interrupted by one bounce back
      run_sweep('0, "R5 release partial");
      run_sweep('0, "R5 release partial");
      run_sweep(p, "R5 release bounce");
      check(key_map == p, "R5 bounce keeps map", 64'(key_map), 64'(p));

      // random walk of presses, releases and short bounces
      held = p;
      for (int s = 0; s < 180; s++) begin
         int nflip;
         if ($urandom % 4 == 0) begin
            nflip = 1 + $urandom % 3;
            for (int f = 0; f < nflip; f++) held[$urandom % KEYS] ^= 1'b1;
         end
         p = held;
         if ($urandom % 5 == 0) p[$urandom % KEYS] ^= 1'b1;
         run_sweep(p, "R4 R5 random sweep");
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule